// File: doc/BRIEF.md
# Quadrature Encoder Times-Four Position Counter

This block turns the two phase outputs and the once-per-turn marker of an incremental shaft encoder into a signed relative position. The three lines are asynchronous to the system clock, so each is first retimed through a short flip-flop chain. The two phase lines are then treated as a two-bit state. Every legal change of that state is one count, which gives four counts per encoder period.

For every count the block emits a one-cycle forward strobe or a one-cycle reverse strobe. It also updates a registered direction flag. An up/down accumulator turns the strobes into the position. A change in which both phase lines move within the same sample cannot be resolved. Such a change is dropped and raises a sticky error flag.

A rising edge of the marker line always captures the position into a separate register. When index clearing is enabled, the same edge also zeroes the position. This lets the host either observe where the marker fell or re-reference the axis to it.

Top module: `qenc_x4_counter`

## Requirements
- R1: With the default two retiming stages, a change on enc_a, enc_b or enc_z that occurs before a rising clock edge produces its strobe during the cycle that follows the third rising edge. The position reflects the change after the fourth rising edge.
- R2: Each legal change of the phase state produces exactly one strobe, lasting one cycle. One full encoder period therefore yields four counts.
- R3: The phase state is {enc_a, enc_b}. The order 00, 01, 11, 10, 00 is forward and pulses fwd_pulse. The opposite order is reverse and pulses rev_pulse. The two strobes are never high together.
- R4: The position rises by one on each forward strobe and falls by one on each reverse strobe. It holds when there is no strobe.
- R5: dir_fwd goes to 1 with a forward count and to 0 with a reverse count. It holds between counts.
- R6: A change in which both phase bits differ from the previous sample produces no strobe and no position change. It sets err_illegal, which then stays at 1 until reset. Counting continues from the new phase state.
- R7: When idx_clr_en is 1, a rising edge of enc_z sets the position to zero. The clear takes the same latency as a count and wins over a count in the same cycle. When idx_clr_en is 0, enc_z leaves the position unchanged.
- R8: Every rising edge of enc_z, whatever the value of idx_clr_en, copies the position held just before that update into index_pos. A falling edge of enc_z has no effect.
- R9: The position is a POS_W-bit two's-complement value (default 32). It wraps from the most positive value to the most negative one on overflow, and the other way on underflow.
- R10: A synchronous active-high reset clears position, index_pos, dir_fwd, err_illegal and both strobes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Encoder once-per-turn marker, asynchronous |
| idx_clr_en | input | 1 | Zero the position on a marker rising edge |
| fwd_pulse | output | 1 | One-cycle forward count strobe |
| rev_pulse | output | 1 | One-cycle reverse count strobe |
| dir_fwd | output | 1 | Direction of the last count, 1 = forward |
| err_illegal | output | 1 | Sticky flag for a double-bit phase change |
| position | output | POS_W | Signed accumulated position |
| index_pos | output | POS_W | Position captured at the last marker rising edge |

## Verification
The hardest cases to reach are a double-bit phase change and a marker edge that lands in the same cycle as a count. A real encoder never moves both lines at once, and its marker normally sits between counts. The bench produces both cases by driving the lines together on one falling clock edge, so that they cross the retiming chain in the same cycle. It also sweeps all sixteen pairs of previous and next phase state. Before each pair it resets the design and walks it to the starting state through legal forward steps, so that every legal, idle and illegal transition is seen from a known origin. A narrow 8-bit position is used so that wrap-around in both directions is reached in a few hundred steps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Map the Gray-coded phase state {A,B} onto its position in the forward cycle.
  function automatic logic [1:0] phase_index(input logic [1:0] ab);
    logic [1:0] idx;
    idx[1] = ab[1];
    idx[0] = ab[1] ^ ab[0];
    return idx;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_i,
  input  logic b_i,
  input  logic z_i,
  output logic fwd_o,
  output logic rev_o,
  output logic dir_o,
  output logic err_o,
  output logic z_rise_o
);

  logic [1:0] ab_cur;
  logic [1:0] ab_prev;
  logic       z_prev;
  logic [1:0] phase_delta;
  step_e      step;

  assign ab_cur      = {a_i, b_i};
  assign phase_delta = phase_index(ab_cur) - phase_index(ab_prev);

  always_comb begin
    case (phase_delta)
      2'd1:    step = STEP_FWD;
      2'd3:    step = STEP_REV;
      2'd2:    step = STEP_BAD;
      default: step = STEP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_prev  <= 2'b00;
      z_prev   <= 1'b0;
      fwd_o    <= 1'b0;
      rev_o    <= 1'b0;
      dir_o    <= 1'b0;
      err_o    <= 1'b0;
      z_rise_o <= 1'b0;
    end else begin
      ab_prev  <= ab_cur;
      z_prev   <= z_i;
      fwd_o    <= (step == STEP_FWD);
      rev_o    <= (step == STEP_REV);
      z_rise_o <= z_i & ~z_prev;
      if (step == STEP_FWD)      dir_o <= 1'b1;
      else if (step == STEP_REV) dir_o <= 1'b0;
      if (step == STEP_BAD)      err_o <= 1'b1;
    end
  end

  // R3: the two strobes never coincide
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fwd_o && rev_o));

  // R6: a double-bit change yields no strobe and raises the flag
  a_r6_bad_no_count: assert property (@(posedge clk) disable iff (rst)
    ((ab_cur ^ ab_prev) == 2'b11) |=> (!fwd_o && !rev_o && err_o));

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  // R5: direction agrees with the strobe it accompanies
  a_r5_dir_fwd: assert property (@(posedge clk) disable iff (rst)
    fwd_o |-> dir_o);
  a_r5_dir_rev: assert property (@(posedge clk) disable iff (rst)
    rev_o |-> !dir_o);

  // R5: direction holds while no count is made
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (!fwd_o && !rev_o) |-> $stable(dir_o));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fwd_i,
  input  logic                    rev_i,
  input  logic                    z_rise_i,
  input  logic                    clr_en_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic signed [POS_W-1:0] idx_pos_o
);

  localparam logic [POS_W-1:0] UNIT = {{(POS_W-1){1'b0}}, 1'b1};

  logic do_clear;
  assign do_clear = z_rise_i & clr_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o     <= '0;
      idx_pos_o <= '0;
    end else begin
      if (z_rise_i) idx_pos_o <= pos_o;
      if (do_clear)   pos_o <= '0;
      else if (fwd_i) pos_o <= pos_o + UNIT;
      else if (rev_i) pos_o <= pos_o - UNIT;
    end
  end

  // R4: increment on a forward strobe
  a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
    (fwd_i && !do_clear) |=> (pos_o == $past(pos_o) + UNIT));

  // R4: decrement on a reverse strobe
  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (rev_i && !do_clear) |=> (pos_o == $past(pos_o) - UNIT));

  // R4: hold with no strobe and no clear
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!fwd_i && !rev_i && !do_clear) |=> $stable(pos_o));

  // R7: index clear zeroes the position
  a_r7_index_clear: assert property (@(posedge clk) disable iff (rst)
    do_clear |=> (pos_o == '0));

  // R8: the marker edge captures the prior position
  a_r8_index_latch: assert property (@(posedge clk) disable iff (rst)
    z_rise_i |=> (idx_pos_o == $past(pos_o)));

endmodule

// File: rtl/qenc_x4_counter.sv
module qenc_x4_counter #(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enc_a,
  input  logic                    enc_b,
  input  logic                    enc_z,
  input  logic                    idx_clr_en,
  output logic                    fwd_pulse,
  output logic                    rev_pulse,
  output logic                    dir_fwd,
  output logic                    err_illegal,
  output logic signed [POS_W-1:0] position,
  output logic signed [POS_W-1:0] index_pos
);

  localparam int N_LINES = 3;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] sync_lines;
  logic               z_rise;

  assign raw_lines = {enc_a, enc_b, enc_z};

  qenc_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_lines),
    .dout (sync_lines)
  );

  qenc_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .a_i      (sync_lines[2]),
    .b_i      (sync_lines[1]),
    .z_i      (sync_lines[0]),
    .fwd_o    (fwd_pulse),
    .rev_o    (rev_pulse),
    .dir_o    (dir_fwd),
    .err_o    (err_illegal),
    .z_rise_o (z_rise)
  );

  qenc_counter #(
    .POS_W (POS_W)
  ) u_counter (
    .clk       (clk),
    .rst       (rst),
    .fwd_i     (fwd_pulse),
    .rev_i     (rev_pulse),
    .z_rise_i  (z_rise),
    .clr_en_i  (idx_clr_en),
    .pos_o     (position),
    .idx_pos_o (index_pos)
  );

endmodule

// File: tb/tb_qenc_x4_counter.sv
`timescale 1ns/1ps
module tb_qenc_x4_counter;

  localparam int POS_W = 8;

  logic clk = 1'b0;
  logic rst;
  logic enc_a, enc_b, enc_z, idx_clr_en;
  logic fwd_pulse, rev_pulse, dir_fwd, err_illegal;
  logic signed [POS_W-1:0] position, index_pos;

  always #4 clk = ~clk;

  qenc_x4_counter #(.POS_W(POS_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .idx_clr_en(idx_clr_en), .fwd_pulse(fwd_pulse), .rev_pulse(rev_pulse),
    .dir_fwd(dir_fwd), .err_illegal(err_illegal),
    .position(position), .index_pos(index_pos)
  );

  int total = 0;
  int bad   = 0;

  logic [POS_W-1:0] exp_pos, exp_idx;
  logic             exp_dir, exp_err;
  logic [1:0]       cur_ab;
  logic             cur_z;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] next_fwd(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] next_rev(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] ab_of(input int k);
    case (k)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    enc_a = 1'b0; enc_b = 1'b0; enc_z = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    exp_pos = '0; exp_idx = '0; exp_dir = 1'b0; exp_err = 1'b0;
    cur_ab = 2'b00; cur_z = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Drive new line values at a falling edge, watch the strobes, then check state.
  task automatic apply(input logic na, input logic nb, input logic nz);
    int kind; // 0 none, 1 fwd, 2 rev, 3 illegal
    int nf, nr, first_i;
    logic [1:0] nab;
    bit zr;
    nab = {na, nb};
    if (nab == cur_ab)                kind = 0;
    else if (nab == next_fwd(cur_ab)) kind = 1;
    else if (nab == next_rev(cur_ab)) kind = 2;
    else                              kind = 3;
    zr = nz && !cur_z;
    enc_a = na; enc_b = nb; enc_z = nz;
    nf = 0; nr = 0; first_i = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (fwd_pulse) nf++;
      if (rev_pulse) nr++;
      if ((fwd_pulse || rev_pulse) && first_i == 0) first_i = i;
    end
    if (zr) exp_idx = exp_pos;
    if (zr && idx_clr_en)  exp_pos = '0;
    else if (kind == 1)    exp_pos = exp_pos + 1'b1;
    else if (kind == 2)    exp_pos = exp_pos - 1'b1;
    if (kind == 1) exp_dir = 1'b1;
    if (kind == 2) exp_dir = 1'b0;
    if (kind == 3) exp_err = 1'b1;
    cur_ab = nab; cur_z = nz;
    if (kind == 1 || kind == 2)
      chk(first_i == 3, "R1", "strobe cycle", first_i, 3);
    chk(nf == (kind == 1 ? 1 : 0), kind == 3 ? "R6" : "R2", "fwd strobes", nf, kind == 1 ? 1 : 0);
    chk(nr == (kind == 2 ? 1 : 0), kind == 3 ? "R6" : "R3", "rev strobes", nr, kind == 2 ? 1 : 0);
    chk(position === exp_pos, "R4", "position", longint'(position), longint'($signed(exp_pos)));
    chk(dir_fwd === exp_dir, "R5", "direction", dir_fwd, exp_dir);
    chk(err_illegal === exp_err, "R6", "error flag", err_illegal, exp_err);
    chk(index_pos === exp_idx, "R8", "index capture", longint'(index_pos), longint'($signed(exp_idx)));
  endtask

  task automatic step(input bit forward);
    logic [1:0] n;
    n = forward ? next_fwd(cur_ab) : next_rev(cur_ab);
    apply(n[1], n[0], cur_z);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    idx_clr_en = 1'b0;
    do_reset();
    // R10: reset state
    chk(position === '0 && index_pos === '0, "R10", "reset position", longint'(position), 0);
    chk(!dir_fwd && !err_illegal && !fwd_pulse && !rev_pulse, "R10", "reset flags",
        {dir_fwd, err_illegal, fwd_pulse, rev_pulse}, 0);

    // R2/R3: three full forward periods, then twenty reverse counts
    repeat (12) step(1'b1);
    chk(position === 8'sd12, "R2", "four counts per period", longint'(position), 12);
    repeat (20) step(1'b0);
    chk(position === -8'sd8, "R4", "net after reverse", longint'(position), -8);

    // R9: wrap upward and downward
    do_reset();
    repeat (130) step(1'b1);
    chk(position === 8'sh82, "R9", "upward wrap", longint'(position), -126);
    do_reset();
    step(1'b0);
    chk(position === 8'shFF, "R9", "downward wrap", longint'(position), -1);

    // R7/R8: marker without clear, then with clear, then with a simultaneous count
    do_reset();
    repeat (5) step(1'b1);
    apply(cur_ab[1], cur_ab[0], 1'b1);
    chk(position === 8'sd5, "R7", "no clear when disabled", longint'(position), 5);
    apply(cur_ab[1], cur_ab[0], 1'b0);
    chk(index_pos === 8'sd5, "R8", "falling marker ignored", longint'(index_pos), 5);
    idx_clr_en = 1'b1;
    repeat (3) step(1'b1);
    apply(cur_ab[1], cur_ab[0], 1'b1);
    chk(position === 8'sd0, "R7", "clear on marker", longint'(position), 0);
    chk(index_pos === 8'sd8, "R8", "capture before clear", longint'(index_pos), 8);
    apply(cur_ab[1], cur_ab[0], 1'b0);
    repeat (2) step(1'b0);
    begin
      logic [1:0] n;
      n = next_fwd(cur_ab);
      apply(n[1], n[0], 1'b1);
    end
    chk(position === 8'sd0, "R7", "clear beats count", longint'(position), 0);
    chk(index_pos === -8'sd2, "R8", "capture with count", longint'(index_pos), -2);
    idx_clr_en = 1'b0;

    // R3/R6: every pair of previous and next phase state
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] t;
        do_reset();
        repeat (p) step(1'b1);
        t = ab_of(n);
        apply(t[1], t[0], 1'b0);
      end
    end
    // R6: flag persists through later legal counts, which still count
    begin
      logic [1:0] bad_ab;
      do_reset();
      step(1'b1);
      bad_ab = ~cur_ab;
      apply(bad_ab[1], bad_ab[0], 1'b0);
      repeat (3) step(1'b1);
      chk(err_illegal === 1'b1, "R6", "sticky error", err_illegal, 1);
      chk(position === 8'sd4, "R6", "count resumes", longint'(position), 4);
    end

    finish_run();
  end

endmodule